// File: doc/BRIEF.md
# Read/Write Mode Coalescing Arbiter

This block sits beside the command queues of a DRAM controller and decides whether the controller is currently serving reads or writes. Grouping commands of one kind cuts the number of data-bus turnarounds, each of which costs idle cycles. The arbiter looks at how many reads and how many writes are waiting. It also sees a pulse each time a command of the current kind issues. It reports the active mode and a one-cycle strobe whenever that mode changes.

Each mode has its own time budget, and the two defaults are deliberately unequal: reads get 256 units and writes get 128. A budget is held in a 10-bit down-counter. The mode flips when the budget runs out and work of the other kind is waiting. It also flips at once when nothing of the current kind is left but the other kind has work. A build-time choice selects the budget unit. By default the unit is a clock cycle in which any work is waiting. The alternative unit is an issued command.

Top module: `rw_mode_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `mode_is_write` is 0 (read mode) and `mode_switch` is 0. The read budget is loaded at reset.
- R2: `mode_switch` is 1 in exactly those cycles where `mode_is_write` differs from its value in the previous cycle, so the strobe lasts one cycle per change.
- R3: With reads and writes both waiting, the cycle-unit arbiter stays in read mode for exactly `RD_BUDGET` cycles after entering it. The budget counter always holds a value from 1 to the larger budget.
- R4: With reads and writes both waiting, the cycle-unit arbiter stays in write mode for exactly `WR_BUDGET` cycles after entering it.
- R5: If the current kind has a waiting count of zero and the other kind's count is nonzero, the mode flips at the next clock edge, whatever budget is left, and the new mode's budget is loaded in full.
- R6: While both waiting counts are zero, the mode holds and the budget stops counting. When work returns, the remainder of the budget continues.
- R7: If the budget runs out while only the current kind is waiting, the mode holds and the budget reloads in full for that same mode.
- R8: With `COUNT_ISSUES`=1, the budget drops only on cycles where `issue_pulse` is 1 and some work is waiting. With both kinds waiting, read mode then ends on the `RD_BUDGET`-th such pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_waiting | input | PEND_W | Number of reads waiting in the queues |
| wr_waiting | input | PEND_W | Number of writes waiting in the queues |
| issue_pulse | input | 1 | A command of the current kind issued this cycle |
| mode_is_write | output | 1 | 0 = read mode, 1 = write mode |
| mode_switch | output | 1 | High for the first cycle of a new mode |

## Verification
Both outputs come from registers. A decision made from the inputs present before edge N therefore shows up on the outputs right after edge N, and the strobe and the new mode appear in the same cycle. The bench changes its inputs on falling edges and samples on the next falling edge, so every expected value is due exactly one edge after its stimulus. Run lengths are measured from the falling edge on which the strobe is seen up to the next strobe, and that count must equal the budget in cycles.

// File: rtl/rw_arb_pkg.sv
package rw_arb_pkg;

  typedef enum logic {
    MODE_READ  = 1'b0,
    MODE_WRITE = 1'b1
  } rw_mode_e;

  function automatic rw_mode_e flip_mode(input rw_mode_e m);
    return (m == MODE_READ) ? MODE_WRITE : MODE_READ;
  endfunction

  // Reduce a waiting count to "something is waiting".
  function automatic logic has_work(input logic [31:0] count);
    return count != 32'd0;
  endfunction

endpackage

// File: rtl/rw_pend_sense.sv
module rw_pend_sense
  import rw_arb_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  rw_mode_e          mode,
  input  logic [PEND_W-1:0] rd_waiting,
  input  logic [PEND_W-1:0] wr_waiting,
  output logic              cur_pend,
  output logic              oth_pend,
  output logic              any_pend
);
  logic rd_has, wr_has;

  always_comb begin
    rd_has   = has_work(32'(rd_waiting));
    wr_has   = has_work(32'(wr_waiting));
    cur_pend = (mode == MODE_READ) ? rd_has : wr_has;
    oth_pend = (mode == MODE_READ) ? wr_has : rd_has;
    any_pend = rd_has | wr_has;
  end
endmodule

// File: rtl/rw_budget_ctr.sv
module rw_budget_ctr #(
  parameter int CNT_W        = 10,
  parameter int COUNT_ISSUES = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] init_val,
  input  logic             any_pend,
  input  logic             issue_pulse,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             tick,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  generate
    if (COUNT_ISSUES != 0) begin : g_issue_unit
      assign tick = any_pend & issue_pulse;
    end else begin : g_cycle_unit
      assign tick = any_pend;
    end
  endgenerate

  assign expire = tick && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= init_val;
    else if (load)  cnt <= load_val;
    else if (tick)  cnt <= cnt - ONE;
  end
endmodule

// File: rtl/rw_mode_reg.sv
module rw_mode_reg
  import rw_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     do_switch,
  output rw_mode_e mode,
  output logic     strobe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= MODE_READ;
      strobe <= 1'b0;
    end else begin
      mode   <= do_switch ? flip_mode(mode) : mode;
      strobe <= do_switch;
    end
  end
endmodule

// File: rtl/rw_mode_arbiter.sv
module rw_mode_arbiter
  import rw_arb_pkg::*;
#(
  parameter int RD_BUDGET    = 256,
  parameter int WR_BUDGET    = 128,
  parameter int CNT_W        = 10,
  parameter int PEND_W       = 4,
  parameter int COUNT_ISSUES = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PEND_W-1:0] rd_waiting,
  input  logic [PEND_W-1:0] wr_waiting,
  input  logic              issue_pulse,
  output logic              mode_is_write,
  output logic              mode_switch
);
  localparam int BUDGET_MAX = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_BUDGET);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_BUDGET);

  generate
    if (RD_BUDGET < 1 || RD_BUDGET > BUDGET_MAX) begin : g_bad_rd
      $error("read budget out of range");
    end
    if (WR_BUDGET < 1 || WR_BUDGET > BUDGET_MAX) begin : g_bad_wr
      $error("write budget out of range");
    end
  endgenerate

  function automatic logic [CNT_W-1:0] budget_for(input rw_mode_e m);
    return (m == MODE_READ) ? RD_LOAD : WR_LOAD;
  endfunction

  rw_mode_e         mode, next_mode;
  logic             cur_pend, oth_pend, any_pend;
  logic             tick, budget_expire, early_sw, expire_sw, do_switch, ctr_load;
  logic [CNT_W-1:0] cnt, load_val;

  rw_pend_sense #(.PEND_W(PEND_W)) u_sense (
    .mode(mode), .rd_waiting(rd_waiting), .wr_waiting(wr_waiting),
    .cur_pend(cur_pend), .oth_pend(oth_pend), .any_pend(any_pend)
  );

  // Named switch events, observed by the bound checker.
  assign early_sw  = !cur_pend && oth_pend;
  assign expire_sw = budget_expire && oth_pend;
  assign do_switch = early_sw | expire_sw;
  assign next_mode = do_switch ? flip_mode(mode) : mode;
  assign load_val  = budget_for(next_mode);
  assign ctr_load  = do_switch | budget_expire;

  rw_budget_ctr #(.CNT_W(CNT_W), .COUNT_ISSUES(COUNT_ISSUES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .init_val(RD_LOAD), .any_pend(any_pend),
    .issue_pulse(issue_pulse), .load(ctr_load), .load_val(load_val),
    .tick(tick), .expire(budget_expire), .cnt(cnt)
  );

  rw_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .do_switch(do_switch),
    .mode(mode), .strobe(mode_switch)
  );

  assign mode_is_write = (mode == MODE_WRITE);
endmodule

// File: rtl/rw_mode_arbiter_chk.sv
module rw_mode_arbiter_chk #(
  parameter int CNT_W     = 10,
  parameter int PEND_W    = 4,
  parameter int RD_BUDGET = 256,
  parameter int WR_BUDGET = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PEND_W-1:0] rd_waiting,
  input logic [PEND_W-1:0] wr_waiting,
  input logic              mode_is_write,
  input logic              mode_switch,
  input logic              early_sw,
  input logic              budget_expire,
  input logic              oth_pend,
  input logic [CNT_W-1:0]  cnt
);
  localparam int TOP = (RD_BUDGET > WR_BUDGET) ? RD_BUDGET : WR_BUDGET;

  // R2
  strobe_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mode_switch == (mode_is_write != $past(mode_is_write))));

  // R5
  early_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_sw |=> (mode_switch && (mode_is_write != $past(mode_is_write))));

  // R6
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_waiting == '0 && wr_waiting == '0) |=> ($stable(mode_is_write) && $stable(cnt)));

  // R7
  expire_alone_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (budget_expire && !oth_pend) |=> !mode_switch);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) >= 1 && 32'(cnt) <= TOP));
endmodule

bind rw_mode_arbiter rw_mode_arbiter_chk #(
  .CNT_W(CNT_W), .PEND_W(PEND_W), .RD_BUDGET(RD_BUDGET), .WR_BUDGET(WR_BUDGET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_waiting(rd_waiting), .wr_waiting(wr_waiting),
  .mode_is_write(mode_is_write), .mode_switch(mode_switch), .early_sw(early_sw),
  .budget_expire(budget_expire), .oth_pend(oth_pend), .cnt(cnt)
);

// File: tb/tb_rw_mode_arbiter.sv
`timescale 1ns/1ps
module tb_rw_mode_arbiter;
  localparam int RD = 12;
  localparam int WR = 7;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] rd_w = '0, wr_w = '0;
  logic issue = 1'b0;
  logic m0, s0, m1, s1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rw_mode_arbiter #(.RD_BUDGET(RD), .WR_BUDGET(WR), .PEND_W(PW), .COUNT_ISSUES(0)) dut (
    .clk(clk), .rst_n(rst_n), .rd_waiting(rd_w), .wr_waiting(wr_w),
    .issue_pulse(issue), .mode_is_write(m0), .mode_switch(s0));

  rw_mode_arbiter #(.RD_BUDGET(RD), .WR_BUDGET(WR), .PEND_W(PW), .COUNT_ISSUES(1)) dut_iss (
    .clk(clk), .rst_n(rst_n), .rd_waiting(rd_w), .wr_waiting(wr_w),
    .issue_pulse(issue), .mode_is_write(m1), .mode_switch(s1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  bit mm[2]; int mc[2]; bit ms[2];
  function automatic int budget_of(input bit w);
    return w ? WR : RD;
  endfunction

  task automatic model_step(input int k, input bit unit_issue);
    bit rp, wp, cur, oth, tk, ex, sw;
    rp = (rd_w != 0); wp = (wr_w != 0);
    cur = mm[k] ? wp : rp; oth = mm[k] ? rp : wp;
    tk = (rp | wp) && (unit_issue ? issue : 1'b1);
    ex = tk && (mc[k] == 1);
    sw = (!cur && oth) || (ex && oth);
    if (sw) begin mm[k] = !mm[k]; mc[k] = budget_of(mm[k]); end
    else if (ex) mc[k] = budget_of(mm[k]);
    else if (tk) mc[k] = mc[k] - 1;
    ms[k] = sw;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin mm[k] = 0; mc[k] = RD; ms[k] = 0; end
    end else begin
      model_step(0, 1'b0);
      model_step(1, 1'b1);
    end
  end

  // Count falling edges from a seen strobe up to the next strobe of dut.
  task automatic run_length(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); n++;
      if (s0) break;
    end
  endtask

  initial begin
    int n;
    bit m;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 reset mode", m0, 0); chk("R1 reset strobe", s0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle mode", m0, 0); chk("R1 first cycle strobe", s0, 0);

    // R3/R4: both waiting, no issue pulses.
    rd_w = 3; wr_w = 3;
    for (int i = 0; i < 200 && !s0; i++) @(negedge clk);
    chk("R3 first switch to write", m0, 1);
    run_length(n); chk("R4 write run length", n, WR); chk("R4 back in read", m0, 0);
    run_length(n); chk("R3 read run length", n, RD); chk("R3 in write", m0, 1);
    chk("R8 no pulses keeps read", m1, 0);

    // R8: issue-unit arbiter switches on the RD-th pulse.
    for (int i = 0; i < RD - 1; i++) begin
      issue = 1; @(negedge clk); issue = 0; @(negedge clk);
    end
    chk("R8 after RD-1 pulses still read", m1, 0);
    issue = 1; @(negedge clk); issue = 0;
    chk("R8 RD-th pulse switches", m1, 1); chk("R8 strobe", s1, 1);
    @(negedge clk);

    // R5: starve current kind.
    m = m0;
    if (m) begin wr_w = 0; rd_w = 5; end else begin rd_w = 0; wr_w = 5; end
    @(negedge clk);
    chk("R5 early flip", m0, !m); chk("R5 early strobe", s0, 1);
    m = m0;

    // R6: idle gap, then resume.
    rd_w = 0; wr_w = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); chk("R6 idle no strobe", s0, 0);
    end
    chk("R6 idle mode held", m0, m);
    rd_w = 2; wr_w = 2;
    n = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); n++; if (s0) break; end
    chk("R6 budget resumed", n, budget_of(m));
    m = m0;

    // R7: only current kind for one full budget, then both.
    if (m) begin rd_w = 0; wr_w = 4; end else begin wr_w = 0; rd_w = 4; end
    for (int i = 0; i < budget_of(m); i++) begin
      @(negedge clk); chk("R7 stays alone", s0, 0);
    end
    rd_w = 4; wr_w = 4;
    n = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); n++; if (s0) break; end
    chk("R7 budget reloaded", n, budget_of(m));

    // Random phase against the model.
    for (int c = 0; c < 4000; c++) begin
      bit p0, p1;
      p0 = m0; p1 = m1;
      rd_w = ($urandom % 4 == 0) ? 0 : PW'($urandom % 16);
      wr_w = ($urandom % 3 == 0) ? 0 : PW'($urandom % 16);
      issue = ($urandom % 2) == 1;
      @(negedge clk);
      chk("R3 model mode", m0, mm[0]); chk("R5 model strobe", s0, ms[0]);
      chk("R8 model mode", m1, mm[1]); chk("R8 model strobe", s1, ms[1]);
      chk("R2 strobe iff change", s0, (m0 != p0));
      chk("R2 strobe iff change iss", s1, (m1 != p1));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule